// File: doc/BRIEF.md
# Battery Monitor Shutdown Sequencer

This block is the control state machine that takes a battery monitor into its lowest-power state and brings it back out. It gathers the reasons to shut down: a host request, a reset/shutdown pin held high, stack and cell undervoltage, internal and hardware die overtemperature, and a timed re-entry after a wake. It then runs a timed sequence that first turns off the protection FETs and later requests power-down, holding the power-down back while the load pin is still above its wake level.

All timing is counted from a single 1 ms tick input. While powered down, the block watches the thermistor-pin and load-pin wake flags, reports a boot state after waking until the rest of the chip reports boot complete, and can be set to go back to shutdown a programmed number of minutes after the wake. A memory-integrity error normally asks for a watchdog reset; if it arrives within a programmed number of seconds after the previous watchdog reset, the block goes straight to shutdown so that a fault cannot cause an endless reset loop.

Top module: `pwr_shdn_seq`

## Requirements
- R1: After reset, mode is 0 (NORMAL), and fet_off, pwr_down and wdog_req are 0. Mode codes are 0 NORMAL, 1 SLEEP (active state with sleep_in high), 2 SEQ (sequence running), 3 SHUTDOWN, 4 BOOT.
- R2: A one-cycle host_shdn_req starts the sequence (mode 2 on the next cycle). So does rst_shut_pin held high across PIN_HOLD_TICKS consecutive ticks (PIN_HOLD_TICKS equals MS_PER_SEC); a low on the pin restarts that count.
- R3: stack_uv starts the sequence when en_stack_uv is set. A cell_uv bit starts it when en_cell_uv is set and the matching cell_is_ic bit is clear. hw_ot starts it when en_hw_ot is set. With the enable clear, or with only interconnect inputs low, the mode stays 0.
- R4: With en_int_ot set, int_ot held high starts the sequence on tick number cfg_ot_dly+1 of the run, and only from NORMAL or SLEEP. In BOOT it has no effect on mode.
- R5: fet_off rises on tick number cfg_fet_dly+1 after the sequence starts (a delay of 0 acts on the first tick).
- R6: On tick number cfg_sd_dly+1 after the start, the shutdown becomes due. If ld_above_wake is low, the next cycle shows mode 3 with pwr_down and fet_off both 1.
- R7: While a due shutdown sees ld_above_wake high, mode stays 2. Entry to mode 3 follows one cycle after the flag clears.
- R8: Triggers that arrive during a running sequence are ignored and do not restart its tick count.
- R9: In SHUTDOWN, ts2_low or ld_above_wake moves the block to mode 4 with pwr_down 0 and fet_off 1. boot_done then returns it to mode 0 with fet_off 0. In NORMAL, ts2_low and ld_above_wake have no effect.
- R10: With en_reenter set at the wake, the sequence starts again once cfg_reenter_min whole minutes (MS_PER_SEC*SEC_PER_MIN ticks each) have passed since the wake, within three cycles of the completing tick.
- R11: A mem_err with no watchdog reset seen, or with cfg_mem_win_s or more seconds since the last wdog_rst_evt, gives a wdog_req pulse exactly one cycle long and leaves the mode unchanged.
- R12: A mem_err fewer than cfg_mem_win_s seconds after wdog_rst_evt moves the block straight to mode 3 with pwr_down 1, and no wdog_req.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle 1 ms time strobe |
| host_shdn_req | input | 1 | Host shutdown request pulse |
| rst_shut_pin | input | 1 | Reset/shutdown pin level |
| stack_uv | input | 1 | Stack voltage below threshold |
| cell_uv | input | NCELL | Per-input cell undervoltage flags |
| cell_is_ic | input | NCELL | Input configured as interconnect |
| int_ot | input | 1 | Internal temperature above threshold |
| hw_ot | input | 1 | Hardware die overtemperature |
| ld_above_wake | input | 1 | Load pin above wake level |
| ts2_low | input | 1 | Thermistor pin pulled low |
| mem_err | input | 1 | Memory integrity error pulse |
| wdog_rst_evt | input | 1 | A watchdog reset just happened |
| boot_done | input | 1 | Boot after wake finished |
| sleep_in | input | 1 | Chip is in sleep (for mode report) |
| en_stack_uv | input | 1 | Enable stack undervoltage trigger |
| en_cell_uv | input | 1 | Enable cell undervoltage trigger |
| en_int_ot | input | 1 | Enable internal overtemperature trigger |
| en_hw_ot | input | 1 | Enable hardware overtemperature trigger |
| en_reenter | input | 1 | Enable timed re-entry after wake |
| cfg_ot_dly | input | DLY_W | Overtemperature persistence, ticks |
| cfg_fet_dly | input | DLY_W | FET-off delay, ticks |
| cfg_sd_dly | input | DLY_W | Shutdown delay, ticks |
| cfg_reenter_min | input | MIN_W | Re-entry delay, minutes |
| cfg_mem_win_s | input | SEC_W | Memory-error window, seconds |
| fet_off | output | 1 | Disable all protection FETs |
| pwr_down | output | 1 | Request power-down |
| wdog_req | output | 1 | Watchdog reset request pulse |
| mode | output | 3 | Current mode code |

## Verification
The bench builds the block with NCELL=4, MS_PER_SEC=4 and SEC_PER_MIN=3, so a second is four ticks, the pin-hold window is four ticks and a minute is twelve. With these values, the re-entry timer and the memory-error window can be crossed exactly at their boundary ticks within a short run. The 8-bit delay fields and 4-bit minute and second fields still allow the zero-delay case and the off-by-one ticks on both sides of each programmed delay.

// File: rtl/pwr_shdn_pkg.sv
package pwr_shdn_pkg;

  typedef enum logic [2:0] {
    MODE_NORMAL = 3'd0,
    MODE_SLEEP  = 3'd1,
    MODE_SEQ    = 3'd2,
    MODE_SHDN   = 3'd3,
    MODE_BOOT   = 3'd4
  } mode_e;

  typedef enum logic [1:0] {
    ST_ACTIVE = 2'd0,
    ST_SEQ    = 2'd1,
    ST_SHDN   = 2'd2,
    ST_BOOT   = 2'd3
  } state_e;

  function automatic logic [2:0] mode_code(state_e s, logic slp);
    case (s)
      ST_ACTIVE: mode_code = slp ? MODE_SLEEP : MODE_NORMAL;
      ST_SEQ:    mode_code = MODE_SEQ;
      ST_SHDN:   mode_code = MODE_SHDN;
      default:   mode_code = MODE_BOOT;
    endcase
  endfunction

endpackage

// File: rtl/shdn_timebase.sv
// Divides the 1 ms tick into a strobe every PERIOD ticks; restartable.
module shdn_timebase #(
  parameter int PERIOD = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic tick,
  output logic stb
);
  localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end
  end

  assign stb = tick && !clr && (cnt == LAST);
endmodule

// File: rtl/shdn_trig.sv
// Qualifies the shutdown sources and merges them into one start request.
module shdn_trig #(
  parameter int NCELL      = 10,
  parameter int HOLD_TICKS = 1000,
  parameter int DLY_W      = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             host_req,
  input  logic             pin,
  input  logic             stack_uv,
  input  logic [NCELL-1:0] cell_uv,
  input  logic [NCELL-1:0] cell_is_ic,
  input  logic             int_ot,
  input  logic             hw_ot,
  input  logic             en_stack,
  input  logic             en_cell,
  input  logic             en_int_ot,
  input  logic             en_hw_ot,
  input  logic [DLY_W-1:0] ot_dly,
  output logic             start
);
  localparam int HW = $clog2(HOLD_TICKS + 1);
  localparam logic [HW-1:0] HOLD_LAST = HW'(HOLD_TICKS - 1);
  localparam logic [HW-1:0] HOLD_FULL = HW'(HOLD_TICKS);

  logic [HW-1:0]    pin_cnt;
  logic [DLY_W-1:0] ot_cnt;
  logic [NCELL-1:0] cell_q;
  logic             pin_fire;
  logic             ot_fire;

  // only inputs that measure real cells may trigger
  for (genvar i = 0; i < NCELL; i++) begin : g_cell
    assign cell_q[i] = cell_uv[i] & ~cell_is_ic[i];
  end

  always_ff @(posedge clk) begin
    if (rst || !pin) begin
      pin_cnt <= '0;
    end else if (tick && pin_cnt != HOLD_FULL) begin
      pin_cnt <= pin_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !int_ot || !en_int_ot) begin
      ot_cnt <= '0;
    end else if (tick && ot_cnt != '1) begin
      ot_cnt <= ot_cnt + 1'b1;
    end
  end

  assign pin_fire = tick && pin && (pin_cnt == HOLD_LAST);
  assign ot_fire  = tick && en_int_ot && int_ot && (ot_cnt >= ot_dly);

  assign start = host_req | pin_fire | ot_fire
               | (en_stack & stack_uv)
               | (en_cell & (|cell_q))
               | (en_hw_ot & hw_ot);
endmodule

// File: rtl/shdn_memguard.sv
// Tracks whether the last watchdog reset is recent enough that a memory
// error must end in shutdown rather than another reset.
module shdn_memguard #(
  parameter int MS_PER_SEC = 1000,
  parameter int SEC_W      = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             wdog_evt,
  input  logic [SEC_W-1:0] win_sec,
  output logic             win_open
);
  logic             sec_stb;
  logic             armed;
  logic [SEC_W-1:0] secs;

  shdn_timebase #(.PERIOD(MS_PER_SEC)) u_sec (
    .clk (clk),
    .rst (rst),
    .clr (wdog_evt),
    .tick(tick),
    .stb (sec_stb)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      armed <= 1'b0;
      secs  <= '0;
    end else if (wdog_evt) begin
      armed <= 1'b1;
      secs  <= '0;
    end else if (sec_stb && secs != '1) begin
      secs <= secs + 1'b1;
    end
  end

  assign win_open = armed && (secs < win_sec);
endmodule

// File: rtl/pwr_shdn_seq.sv
module pwr_shdn_seq
  import pwr_shdn_pkg::*;
#(
  parameter int NCELL       = 10,
  parameter int MS_PER_SEC  = 1000,
  parameter int SEC_PER_MIN = 60,
  parameter int DLY_W       = 16,
  parameter int SEC_W       = 8,
  parameter int MIN_W       = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             host_shdn_req,
  input  logic             rst_shut_pin,
  input  logic             stack_uv,
  input  logic [NCELL-1:0] cell_uv,
  input  logic [NCELL-1:0] cell_is_ic,
  input  logic             int_ot,
  input  logic             hw_ot,
  input  logic             ld_above_wake,
  input  logic             ts2_low,
  input  logic             mem_err,
  input  logic             wdog_rst_evt,
  input  logic             boot_done,
  input  logic             sleep_in,
  input  logic             en_stack_uv,
  input  logic             en_cell_uv,
  input  logic             en_int_ot,
  input  logic             en_hw_ot,
  input  logic             en_reenter,
  input  logic [DLY_W-1:0] cfg_ot_dly,
  input  logic [DLY_W-1:0] cfg_fet_dly,
  input  logic [DLY_W-1:0] cfg_sd_dly,
  input  logic [MIN_W-1:0] cfg_reenter_min,
  input  logic [SEC_W-1:0] cfg_mem_win_s,
  output logic             fet_off,
  output logic             pwr_down,
  output logic             wdog_req,
  output logic [2:0]       mode
);
  localparam int TICKS_PER_MIN = MS_PER_SEC * SEC_PER_MIN;

  state_e           state, state_n;
  logic             trig_start;
  logic             win_open;
  logic             min_stb;
  logic             wake_evt;
  logic             mem_hit;
  logic             mem_wd;
  logic             re_armed;
  logic             re_fire;
  logic [MIN_W-1:0] rmin;
  logic [DLY_W-1:0] seq_cnt;
  logic             sd_due;

  shdn_trig #(
    .NCELL     (NCELL),
    .HOLD_TICKS(MS_PER_SEC),
    .DLY_W     (DLY_W)
  ) u_trig (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .host_req  (host_shdn_req),
    .pin       (rst_shut_pin),
    .stack_uv  (stack_uv),
    .cell_uv   (cell_uv),
    .cell_is_ic(cell_is_ic),
    .int_ot    (int_ot),
    .hw_ot     (hw_ot),
    .en_stack  (en_stack_uv),
    .en_cell   (en_cell_uv),
    .en_int_ot (en_int_ot),
    .en_hw_ot  (en_hw_ot),
    .ot_dly    (cfg_ot_dly),
    .start     (trig_start)
  );

  shdn_memguard #(
    .MS_PER_SEC(MS_PER_SEC),
    .SEC_W     (SEC_W)
  ) u_mem (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .wdog_evt(wdog_rst_evt),
    .win_sec (cfg_mem_win_s),
    .win_open(win_open)
  );

  // minute strobe restarted at each wake
  shdn_timebase #(.PERIOD(TICKS_PER_MIN)) u_min (
    .clk (clk),
    .rst (rst),
    .clr (wake_evt),
    .tick(tick),
    .stb (min_stb)
  );

  assign wake_evt = (state == ST_SHDN) && (ts2_low || ld_above_wake);
  assign mem_hit  = mem_err && (state != ST_SHDN) && win_open;
  assign mem_wd   = mem_err && (state != ST_SHDN) && !win_open;
  assign re_fire  = re_armed && en_reenter && (rmin >= cfg_reenter_min);

  always_comb begin
    state_n = state;
    case (state)
      ST_ACTIVE: begin
        if (mem_hit)                  state_n = ST_SHDN;
        else if (trig_start || re_fire) state_n = ST_SEQ;
      end
      ST_SEQ: begin
        if (mem_hit)                         state_n = ST_SHDN;
        else if (sd_due && !ld_above_wake)   state_n = ST_SHDN;
      end
      ST_SHDN: begin
        if (wake_evt) state_n = ST_BOOT;
      end
      default: begin
        if (mem_hit)        state_n = ST_SHDN;
        else if (boot_done) state_n = ST_ACTIVE;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_ACTIVE;
      mode     <= MODE_NORMAL;
      pwr_down <= 1'b0;
      wdog_req <= 1'b0;
      fet_off  <= 1'b0;
    end else begin
      state    <= state_n;
      mode     <= mode_code(state_n, sleep_in);
      pwr_down <= (state_n == ST_SHDN);
      wdog_req <= mem_wd;
      if (state_n == ST_ACTIVE)
        fet_off <= 1'b0;
      else if (state_n != ST_SEQ)
        fet_off <= 1'b1;
      else if (state == ST_SEQ && tick && seq_cnt >= cfg_fet_dly)
        fet_off <= 1'b1;
    end
  end

  // elapsed ticks since the sequence began
  always_ff @(posedge clk) begin
    if (rst || state != ST_SEQ) begin
      seq_cnt <= '0;
      sd_due  <= 1'b0;
    end else if (tick) begin
      if (seq_cnt >= cfg_sd_dly) sd_due <= 1'b1;
      if (seq_cnt != '1) seq_cnt <= seq_cnt + 1'b1;
    end
  end

  // timed re-entry after a wake
  always_ff @(posedge clk) begin
    if (rst) begin
      re_armed <= 1'b0;
      rmin     <= '0;
    end else if (wake_evt) begin
      re_armed <= en_reenter;
      rmin     <= '0;
    end else if (re_fire && state == ST_ACTIVE) begin
      re_armed <= 1'b0;
    end else if (min_stb && rmin != '1) begin
      rmin <= rmin + 1'b1;
    end
  end
endmodule

// File: rtl/pwr_shdn_seq_chk.sv
module pwr_shdn_seq_chk
  import pwr_shdn_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic [2:0] mode,
  input logic       fet_off,
  input logic       pwr_down,
  input logic       wdog_req,
  input logic       ld_above_wake,
  input logic       mem_err
);
  a_r6_pwr_needs_fet: assert property (@(posedge clk) disable iff (rst)
    pwr_down |-> fet_off);

  a_r1_mode_legal: assert property (@(posedge clk) disable iff (rst)
    mode <= MODE_BOOT);

  a_r7_ld_holds_entry: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_SEQ && ld_above_wake && !mem_err) |=> mode != MODE_SHDN);

  a_r9_exit_to_boot: assert property (@(posedge clk) disable iff (rst)
    ($past(mode) == MODE_SHDN && mode != MODE_SHDN) |-> mode == MODE_BOOT);

  a_r9_boot_fet_off: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_BOOT) |-> fet_off);

  a_r11_wdog_one_cycle: assert property (@(posedge clk) disable iff (rst)
    wdog_req |=> !wdog_req);

  a_r12_shdn_entry_path: assert property (@(posedge clk) disable iff (rst)
    $rose(pwr_down) |-> ($past(mode) == MODE_SEQ || $past(mem_err)));
endmodule

bind pwr_shdn_seq pwr_shdn_seq_chk chk_i (
  .clk          (clk),
  .rst          (rst),
  .mode         (mode),
  .fet_off      (fet_off),
  .pwr_down     (pwr_down),
  .wdog_req     (wdog_req),
  .ld_above_wake(ld_above_wake),
  .mem_err      (mem_err)
);

// File: tb/pwr_shdn_seq_tb_top.sv
`timescale 1ns/1ps
module pwr_shdn_seq_tb_top;
  localparam int NCELL = 4;
  localparam int MSPS  = 4;
  localparam int SPM   = 3;
  localparam int DW    = 8;
  localparam int SW    = 4;
  localparam int MW    = 4;

  // {source[3:0], enable, expect_start}
  // source: 0 host, 1 stack, 2 real cell, 3 interconnect-only cell, 4 hw ot
  localparam logic [5:0] VEC [0:7] = '{
    {4'd0, 1'b1, 1'b1}, {4'd1, 1'b1, 1'b1}, {4'd1, 1'b0, 1'b0},
    {4'd2, 1'b1, 1'b1}, {4'd2, 1'b0, 1'b0}, {4'd3, 1'b1, 1'b0},
    {4'd4, 1'b1, 1'b1}, {4'd4, 1'b0, 1'b0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 0, host = 0, pin = 0, suv = 0, iot = 0, hot = 0;
  logic ld = 0, ts2 = 0, merr = 0, wevt = 0, bdone = 0, slp = 0;
  logic [NCELL-1:0] cuv = '0, cic = '0;
  logic en_s = 0, en_c = 0, en_i = 0, en_h = 0, en_r = 0;
  logic [DW-1:0] otd = '0, fetd = '0, sdd = '0;
  logic [MW-1:0] rmin = '0;
  logic [SW-1:0] mwin = '0;
  logic fet_off, pwr_down, wdog_req;
  logic [2:0] mode;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  pwr_shdn_seq #(
    .NCELL(NCELL), .MS_PER_SEC(MSPS), .SEC_PER_MIN(SPM),
    .DLY_W(DW), .SEC_W(SW), .MIN_W(MW)
  ) dut_i (
    .clk(clk), .rst(rst), .tick(tick), .host_shdn_req(host),
    .rst_shut_pin(pin), .stack_uv(suv), .cell_uv(cuv), .cell_is_ic(cic),
    .int_ot(iot), .hw_ot(hot), .ld_above_wake(ld), .ts2_low(ts2),
    .mem_err(merr), .wdog_rst_evt(wevt), .boot_done(bdone), .sleep_in(slp),
    .en_stack_uv(en_s), .en_cell_uv(en_c), .en_int_ot(en_i),
    .en_hw_ot(en_h), .en_reenter(en_r), .cfg_ot_dly(otd),
    .cfg_fet_dly(fetd), .cfg_sd_dly(sdd), .cfg_reenter_min(rmin),
    .cfg_mem_win_s(mwin), .fet_off(fet_off), .pwr_down(pwr_down),
    .wdog_req(wdog_req), .mode(mode)
  );

  task automatic chk(string rq, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
    end
  endtask

  task automatic pulse_host();
    @(negedge clk) host = 1'b1;
    @(negedge clk) host = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk) rst = 1'b1;
    cyc(2);
    rst = 1'b0;
    cyc(1);
  endtask

  // fast path into SHUTDOWN with zero delays
  task automatic go_shdn();
    fetd = '0; sdd = '0;
    pulse_host();
    ticks(1);
    cyc(2);
  endtask

  initial begin
    #(20ns * 150000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 mode", mode, 0);
    chk("R1 fet_off", fet_off, 0);
    chk("R1 pwr_down", pwr_down, 0);
    chk("R1 wdog_req", wdog_req, 0);
    slp = 1'b1; cyc(2);
    chk("R1 sleep code", mode, 1);
    slp = 1'b0; cyc(2);

    // trigger source table (R2, R3)
    for (int i = 0; i < 8; i++) begin
      logic [3:0] src;
      logic en, ex;
      src = VEC[i][5:2];
      en  = VEC[i][1];
      ex  = VEC[i][0];
      do_reset();
      en_s = en; en_c = en; en_h = en;
      cic = 4'b0001;
      case (src)
        4'd0: pulse_host();
        4'd1: suv = 1'b1;
        4'd2: cuv = 4'b0010;
        4'd3: cuv = 4'b0001;
        default: hot = 1'b1;
      endcase
      cyc(3);
      chk((src == 0) ? "R2 host vector" : "R3 source vector", mode, ex ? 2 : 0);
      suv = 0; cuv = '0; hot = 0; en_s = 0; en_c = 0; en_h = 0;
    end

    // R2 pin hold, restart on release
    do_reset();
    pin = 1'b1; ticks(3); cyc(1);
    chk("R2 pin short", mode, 0);
    pin = 1'b0; cyc(1); pin = 1'b1;
    ticks(3); cyc(1);
    chk("R2 pin restarted", mode, 0);
    ticks(1); cyc(1);
    chk("R2 pin held", mode, 2);
    pin = 1'b0;

    // R4 internal overtemperature persistence
    do_reset();
    en_i = 1'b1; otd = 8'd2; iot = 1'b1;
    ticks(2); cyc(1);
    chk("R4 ot early", mode, 0);
    ticks(1); cyc(1);
    chk("R4 ot fires", mode, 2);
    iot = 1'b0;

    // R5 / R6 delays
    do_reset();
    fetd = 8'd2; sdd = 8'd4;
    pulse_host();
    ticks(2); cyc(1);
    chk("R5 fet before", fet_off, 0);
    ticks(1); cyc(1);
    chk("R5 fet after", fet_off, 1);
    ticks(1); cyc(2);
    chk("R6 not yet", mode, 2);
    chk("R6 no pwr", pwr_down, 0);
    ticks(1); cyc(2);
    chk("R6 shutdown", mode, 3);
    chk("R6 pwr_down", pwr_down, 1);

    // R5 zero delay
    do_reset();
    fetd = '0; sdd = 8'd9;
    pulse_host();
    ticks(1); cyc(1);
    chk("R5 zero delay", fet_off, 1);

    // R8 retrigger ignored
    do_reset();
    fetd = 8'd2; sdd = 8'd9;
    pulse_host();
    ticks(2);
    pulse_host();
    ticks(1); cyc(1);
    chk("R8 count kept", fet_off, 1);

    // R7 load pin holds entry
    do_reset();
    fetd = '0; sdd = '0; ld = 1'b1;
    pulse_host();
    ticks(3); cyc(2);
    chk("R7 held", mode, 2);
    ld = 1'b0; cyc(2);
    chk("R7 released", mode, 3);

    // R9 wake and boot
    @(negedge clk) ts2 = 1'b1;
    @(negedge clk) ts2 = 1'b0;
    chk("R9 boot mode", mode, 4);
    chk("R9 boot pwr", pwr_down, 0);
    chk("R9 boot fet", fet_off, 1);
    // R4: overtemperature ignored while booting
    en_i = 1'b1; otd = '0; iot = 1'b1;
    ticks(3); cyc(1);
    chk("R4 ignored in boot", mode, 4);
    iot = 1'b0; en_i = 1'b0;
    @(negedge clk) bdone = 1'b1;
    @(negedge clk) bdone = 1'b0;
    chk("R9 back normal", mode, 0);
    chk("R9 fet on", fet_off, 0);
    ts2 = 1'b1; ld = 1'b1; cyc(3);
    chk("R9 no wake effect", mode, 0);
    ts2 = 1'b0; ld = 1'b0;

    // R9 load-pin wake
    go_shdn();
    @(negedge clk) ld = 1'b1;
    @(negedge clk) ld = 1'b0;
    chk("R9 ld wake", mode, 4);

    // R10 re-entry one minute (12 ticks) after wake
    do_reset();
    en_r = 1'b1; rmin = 4'd1;
    go_shdn();
    @(negedge clk) ts2 = 1'b1;
    @(negedge clk) ts2 = 1'b0;
    @(negedge clk) bdone = 1'b1;
    @(negedge clk) bdone = 1'b0;
    ticks(11); cyc(2);
    chk("R10 before minute", mode, 0);
    ticks(1); cyc(2);
    chk("R10 reentered", mode, 2);
    en_r = 1'b0;

    // R11 memory error without prior watchdog reset
    do_reset();
    mwin = 4'd2;
    @(negedge clk) merr = 1'b1;
    @(negedge clk) merr = 1'b0;
    chk("R11 wdog pulse", wdog_req, 1);
    cyc(1);
    chk("R11 pulse ends", wdog_req, 0);
    chk("R11 mode kept", mode, 0);

    // R12 inside window (7 ticks < 2 s)
    do_reset();
    @(negedge clk) wevt = 1'b1;
    @(negedge clk) wevt = 1'b0;
    ticks(7);
    @(negedge clk) merr = 1'b1;
    @(negedge clk) merr = 1'b0;
    chk("R12 shutdown", mode, 3);
    chk("R12 pwr_down", pwr_down, 1);
    chk("R12 no wdog", wdog_req, 0);

    // R11 window closed (8 ticks = 2 s)
    do_reset();
    @(negedge clk) wevt = 1'b1;
    @(negedge clk) wevt = 1'b0;
    ticks(8);
    @(negedge clk) merr = 1'b1;
    @(negedge clk) merr = 1'b0;
    chk("R11 closed wdog", wdog_req, 1);
    chk("R11 closed mode", mode, 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule